// File: doc/BRIEF.md
# Memory Device Power-State Controller

This controller governs the power mode of a single memory device. The device has four modes. In the full-power mode it serves accesses. A light sleep mode wakes quickly. A deeper sleep mode wakes more slowly. A deep-retention mode keeps its data but takes by far the longest to wake. The further the device sleeps, the less it draws and the longer it takes to become usable again.

The controller watches a request handshake and a count of requests still in flight. Once nothing is in flight and nothing is being asked for, it drops the device at once into the sleep mode picked by a policy input. The idle threshold is zero. If a long stretch passes with no request at all, it pushes the device down to deep retention. A task-complete strobe puts the device into deep retention straight away. A request to a sleeping device starts a wake-up. The grant stays low until the exit delay for the mode it left has run out. Per-mode residency counters and a count of sleep entries give a view of how the device spent its time. A single clear strobe resets all of them.

Top module: `mem_pwr_ctl`

## Requirements
- R1: After reset the mode output reads full power, the grant is high and every counter reads zero. Mode codes are: 0 full power, 1 light sleep, 2 deeper sleep, 3 deep retention.
- R2: The device stays in full power in every cycle in which the in-flight count is nonzero.
- R3: The device may be in full power with no wake-up pending, a zero in-flight count, no request and no task-complete. The next cycle then shows code 1 if policy_sel is 1 and code 2 if policy_sel is 0.
- R4: policy_sel has no effect while the device sleeps. Changing it in a sleep mode leaves the mode unchanged.
- R5: A request seen in a sleep mode makes the next cycle read full power with the grant low. The grant returns high exactly WAKE_LIGHT, WAKE_DEEP or WAKE_RET cycles after that, depending on whether the mode left was code 1, 2 or 3. While the grant is low the requester holds its request.
- R6: A sleep mode is kept until a request arrives, unless task-complete or the long-idle rule acts first.
- R7: Let k be the last cycle in which req_valid was high. A device in code 1 or 2 moves to code 3 at cycle k+IDLE_LIMIT.
- R8: Task-complete puts the device in code 3 on the next cycle from any mode, including during a wake-up. It wins over a request in the same cycle.
- R9: In every cycle, the residency counter of the current mode increases by one. It stays at its maximum value once there.
- R10: lp_entries increases by one for each move from full power into code 1 or 2. Moves into code 3 are not counted.
- R11: A stats_clr strobe makes all five counters read zero on the next cycle. It takes priority over any increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, held until granted |
| req_ready | output | 1 | Grant: device awake and usable |
| inflight | input | IF_W | Number of requests still in flight |
| policy_sel | input | 1 | Sleep target: 0 deeper sleep, 1 light sleep |
| task_done | input | 1 | Force deep retention |
| stats_clr | input | 1 | Clear all counters |
| pstate | output | 2 | Current mode code |
| res_full | output | CNT_W | Cycles spent in full power |
| res_light | output | CNT_W | Cycles spent in light sleep |
| res_deep | output | CNT_W | Cycles spent in deeper sleep |
| res_ret | output | CNT_W | Cycles spent in deep retention |
| lp_entries | output | CNT_W | Entries into light or deeper sleep |

## Verification
Every mode change is due one cycle after the input that causes it, because the mode is a single register. The grant after a wake-up is due exactly the exit delay later, counted from the cycle in which full power first shows. Counters show an increment or a clear one cycle after the cycle they account for. The escalation to deep retention is due IDLE_LIMIT cycles after the last cycle with a request. The driver records each expectation in a queue, tagged with the absolute cycle in which it falls due. The monitor compares only in that cycle, just after the falling edge, so every register on the path has already settled.

// File: rtl/mem_pwr_ctl.sv
`timescale 1ns/1ps
module mem_pwr_ctl #(
  parameter int IF_W       = 4,
  parameter int CNT_W      = 32,
  parameter int WAKE_LIGHT = 1,
  parameter int WAKE_DEEP  = 6,
  parameter int WAKE_RET   = 2500,
  parameter int IDLE_LIMIT = 50000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IF_W-1:0]  inflight,
  input  logic             policy_sel,
  input  logic             task_done,
  input  logic             stats_clr,
  output logic [1:0]       pstate,
  output logic [CNT_W-1:0] res_full,
  output logic [CNT_W-1:0] res_light,
  output logic [CNT_W-1:0] res_deep,
  output logic [CNT_W-1:0] res_ret,
  output logic [CNT_W-1:0] lp_entries
);
  localparam int WW = $clog2(WAKE_RET + 1);
  localparam int IW = $clog2(IDLE_LIMIT + 1);
  localparam logic [1:0] M_FULL = 2'd0, M_LIGHT = 2'd1, M_DEEP = 2'd2, M_RET = 2'd3;

  logic [1:0]    mode, mode_nx;
  logic [WW-1:0] wait_q, wait_nx;
  logic [IW-1:0] quiet;

  wire waking    = wait_q != '0;
  wire long_idle = quiet >= IW'(IDLE_LIMIT - 1);
  wire sleeping  = mode == M_LIGHT || mode == M_DEEP;
  wire enter_lp  = mode == M_FULL && (mode_nx == M_LIGHT || mode_nx == M_DEEP);

  assign req_ready = mode == M_FULL && !waking;
  assign pstate    = mode;

  always_comb begin
    mode_nx = mode;
    wait_nx = waking ? wait_q - 1'b1 : '0;
    if (task_done) begin
      mode_nx = M_RET;
      wait_nx = '0;
    end else begin
      case (mode)
        M_FULL:
          if (!waking && inflight == '0 && !req_valid)
            mode_nx = policy_sel ? M_LIGHT : M_DEEP;
        M_LIGHT, M_DEEP:
          if (req_valid) begin
            mode_nx = M_FULL;
            wait_nx = (mode == M_LIGHT) ? WW'(WAKE_LIGHT) : WW'(WAKE_DEEP);
          end else if (long_idle) begin
            mode_nx = M_RET;
          end
        default:
          if (req_valid) begin
            mode_nx = M_FULL;
            wait_nx = WW'(WAKE_RET);
          end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode   <= M_FULL;
      wait_q <= '0;
      quiet  <= '0;
    end else begin
      mode   <= mode_nx;
      wait_q <= wait_nx;
      if (req_valid) quiet <= '0;
      else if (!long_idle) quiet <= quiet + 1'b1;
    end
  end

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || stats_clr) begin
      res_full   <= '0;
      res_light  <= '0;
      res_deep   <= '0;
      res_ret    <= '0;
      lp_entries <= '0;
    end else begin
      if (mode == M_FULL)  res_full  <= bump(res_full);
      if (mode == M_LIGHT) res_light <= bump(res_light);
      if (mode == M_DEEP)  res_deep  <= bump(res_deep);
      if (mode == M_RET)   res_ret   <= bump(res_ret);
      if (enter_lp)        lp_entries <= bump(lp_entries);
    end
  end

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_FULL && inflight != '0 && !task_done) |=> mode == M_FULL);

  // R5
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_FULL && req_valid && !task_done) |=> (mode == M_FULL && !req_ready));

  // R6
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && !req_valid && !task_done && !long_idle) |=> $stable(mode));

  // R8
  force_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    task_done |=> mode == M_RET);

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&res_ret && !stats_clr) |=> &res_ret);

  // R11
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stats_clr |=> (res_full == '0 && res_light == '0 && res_deep == '0 && res_ret == '0 && lp_entries == '0));
endmodule

// File: tb/mem_pwr_ctl_test.sv
`timescale 1ns/1ps
module mem_pwr_ctl_test;
  localparam int WL = 1, WD = 6, WR = 20, IDLE = 40, CW = 8;

  logic clk = 0, rst_n = 0, req_valid = 0, policy_sel = 0, task_done = 0, stats_clr = 0;
  logic [3:0] inflight = 0;
  logic req_ready;
  logic [1:0] pstate;
  logic [CW-1:0] res_full, res_light, res_deep, res_ret, lp_entries;

  mem_pwr_ctl #(.IF_W(4), .CNT_W(CW), .WAKE_LIGHT(WL), .WAKE_DEEP(WD),
                .WAKE_RET(WR), .IDLE_LIMIT(IDLE)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .inflight(inflight), .policy_sel(policy_sel), .task_done(task_done),
    .stats_clr(stats_clr), .pstate(pstate), .res_full(res_full),
    .res_light(res_light), .res_deep(res_deep), .res_ret(res_ret),
    .lp_entries(lp_entries));

  always #5 clk = ~clk;

  typedef struct { int due; int sig; int val; string tag; } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  localparam int S_MODE = 0, S_RDY = 1, S_FULL = 2, S_LIGHT = 3, S_DEEP = 4, S_RET = 5, S_LP = 6;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int sigval(int s);
    case (s)
      S_MODE:  return int'(pstate);
      S_RDY:   return int'(req_ready);
      S_FULL:  return int'(res_full);
      S_LIGHT: return int'(res_light);
      S_DEEP:  return int'(res_deep);
      S_RET:   return int'(res_ret);
      default: return int'(lp_entries);
    endcase
  endfunction

  task automatic expect_in(int d, int s, int v, string tag);
    exp_t e;
    e.due = cyc + d; e.sig = s; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  always begin
    @(negedge clk);
    #1;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        checks++;
        if (sigval(q[i].sig) !== q[i].val) begin
          fails++;
          $display("FAIL %s signal %0d cycle %0d actual %0d expected %0d",
                   q[i].tag, q[i].sig, cyc, sigval(q[i].sig), q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic wrap_up();
    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard leftover actual %0d expected 0", q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #200us;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    inflight = 1;
    tick(3);
    rst_n = 1;
    // R1 reset state
    expect_in(0, S_MODE, 0, "R1"); expect_in(0, S_RDY, 1, "R1");
    expect_in(0, S_FULL, 0, "R1"); expect_in(0, S_LP, 0, "R1");
    tick(4);
    // R2 busy keeps full power; R9 residency
    expect_in(0, S_MODE, 0, "R2"); expect_in(0, S_FULL, 4, "R9");
    // R3 deeper sleep with policy 0
    inflight = 0; policy_sel = 0;
    expect_in(1, S_MODE, 2, "R3"); expect_in(1, S_RDY, 0, "R3"); expect_in(1, S_LP, 1, "R10");
    tick(1);
    // R4 policy ignored in sleep
    policy_sel = 1;
    tick(3);
    expect_in(0, S_MODE, 2, "R4");
    // R11 clear
    stats_clr = 1;
    tick(1);
    stats_clr = 0;
    expect_in(0, S_FULL, 0, "R11"); expect_in(0, S_DEEP, 0, "R11"); expect_in(0, S_LP, 0, "R11");
    tick(5);
    expect_in(0, S_DEEP, 5, "R9"); expect_in(0, S_FULL, 0, "R9");
    // R5 wake from deeper sleep
    req_valid = 1;
    expect_in(1, S_MODE, 0, "R5"); expect_in(1, S_RDY, 0, "R5");
    expect_in(WD, S_RDY, 0, "R5"); expect_in(WD + 1, S_RDY, 1, "R5");
    tick(WD + 1);
    tick(1);
    req_valid = 0; inflight = 1;
    tick(2);
    // R3 light sleep with policy 1
    inflight = 0;
    expect_in(1, S_MODE, 1, "R3"); expect_in(1, S_LP, 1, "R10");
    tick(1);
    // R5 wake from light sleep
    req_valid = 1;
    expect_in(1, S_MODE, 0, "R5"); expect_in(1, S_RDY, 0, "R5"); expect_in(WL + 1, S_RDY, 1, "R5");
    tick(WL + 1);
    tick(1);
    req_valid = 0;
    // R7 escalation after IDLE cycles without request
    expect_in(1, S_MODE, 1, "R3"); expect_in(1, S_LP, 2, "R10");
    expect_in(IDLE - 1, S_MODE, 1, "R7"); expect_in(IDLE, S_MODE, 3, "R7");
    tick(IDLE + 1);
    // R5 wake from deep retention
    req_valid = 1;
    expect_in(1, S_MODE, 0, "R5"); expect_in(WR, S_RDY, 0, "R5"); expect_in(WR + 1, S_RDY, 1, "R5");
    tick(WR + 1);
    tick(1);
    req_valid = 0; inflight = 3;
    tick(1);
    // R8 task done wins over request
    task_done = 1; req_valid = 1;
    expect_in(1, S_MODE, 3, "R8"); expect_in(1, S_RDY, 0, "R8");
    tick(1);
    task_done = 0; req_valid = 0; inflight = 0;
    tick(3);
    expect_in(0, S_MODE, 3, "R6"); expect_in(0, S_LP, 2, "R10");
    // R8 task done during wake-up
    req_valid = 1;
    tick(2);
    expect_in(0, S_MODE, 0, "R5"); expect_in(0, S_RDY, 0, "R5");
    task_done = 1;
    expect_in(1, S_MODE, 3, "R8");
    tick(1);
    task_done = 0; req_valid = 0;
    // R9 saturation
    stats_clr = 1;
    tick(1);
    stats_clr = 0;
    tick(300);
    expect_in(0, S_RET, 255, "R9"); expect_in(0, S_FULL, 0, "R9");
    tick(2);
    done = 1;
    wrap_up();
  end
endmodule